// File: doc/BRIEF.md
# Paged Memory Write Sequencer

This block sits behind the byte-level front end of a two-wire serial slave. It owns a byte-addressed memory array, takes the address word that the bus master sends, collects up to one page of incoming data bytes in a buffer, and commits them to the array in one timed internal write cycle. It also keeps the current address pointer, so a master can read without sending an address, and it refuses new commands while a write cycle is running.

The front end reports one event per clock. A command can be a write session (two address bytes, then data bytes, then a stop) or a read session (one byte per master request, until a stop). A write session followed directly by a read start, with no stop between them, only loads the pointer. This is how a master reads from a chosen address. Every acknowledged event produces a one-cycle `ack` pulse in the cycle after the event. The front end turns a missing pulse into a not-acknowledge on the bus.

The array holds 2^`AW` bytes in pages of 2^`PW` bytes. A full-size instance uses AW=15 and PW=6: 32768 bytes in 512 pages of 64. The default is kept smaller so that elaboration stays light. The address word is 16 bits, and the bits at and above `AW` are ignored.

Top module: `page_wr_seq`

## Requirements
- R1: After reset, `busy`, `ack` and `rd_vld` are low, and every array byte reads as 0xFF.
- R2: The address word is {first address byte, second address byte}. Its low `AW` bits set the pointer, and higher bits (bit 15 included) have no effect. Each address byte of a write session is acknowledged.
- R3: A stop that ends a write session after at least one accepted data byte raises `busy` from the next cycle for exactly `WR_CYCLES` cycles. Afterwards the written bytes read back.
- R4: Each accepted data byte advances only the low `PW` pointer bits. Bytes beyond one page wrap inside the same page and overwrite earlier buffered bytes, and neighbouring pages stay unchanged.
- R5: Only page positions that received a data byte are committed. All other bytes of the page keep their previous contents.
- R6: While `busy` is high, neither kind of start is acknowledged, and any bytes and stop that follow have no effect.
- R7: `wp` is sampled in the cycle of the second address byte. If it was high, no data byte of that session is acknowledged and nothing is written. A change of `wp` after that sample has no effect on the session.
- R8: An acknowledged read start and every read request return the byte at the pointer on `rd_data` with a `rd_vld` pulse, then advance the pointer. The pointer wraps from address 2^AW-1 to 0.
- R9: A write session that stops before any data byte only loads the pointer. `busy` stays low.
- R10: After a write, the pointer holds the position after the last byte written, wrapped inside its page, so a read start with no address returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp | input | 1 | Write protect, high blocks writes |
| start_wr | input | 1 | Device addressed for a write session |
| start_rd | input | 1 | Device addressed for a read session |
| byte_vld | input | 1 | A byte was received from the master |
| byte_in | input | 8 | Received byte |
| stop | input | 1 | Stop condition seen on the bus |
| rd_next | input | 1 | Master acknowledged, next read byte wanted |
| ack | output | 1 | Pulse: previous event acknowledged |
| rd_vld | output | 1 | Pulse: `rd_data` holds a new byte |
| rd_data | output | 8 | Byte read from the array |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The assertions assume that the front end raises at most one event input per cycle and holds each event for exactly one cycle. They also assume that it sends read requests only inside an acknowledged read session. The bench drives every event from a single task that pulses one input for one clock and then clears all of them, so these assumptions always hold. The protect input is changed only between events.

// File: rtl/page_wr_seq.sv
module page_wr_seq #(
  parameter int AW = 11,
  parameter int PW = 6,
  parameter int WR_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp,
  input  logic       start_wr,
  input  logic       start_rd,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       stop,
  input  logic       rd_next,
  output logic       ack,
  output logic       rd_vld,
  output logic [7:0] rd_data,
  output logic       busy
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_AH, S_AL, S_DAT, S_RD} st_t;

  st_t             st;
  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] filled;
  logic [AW-1:0]   ptr;
  logic [AW-9:0]   hi;
  logic            prot;
  logic [TW-1:0]   timer;

  wire in_dat  = (st == S_DAT);
  wire in_rd   = (st == S_RD);
  wire wr_byte = byte_vld && in_dat && !prot;
  wire commit  = stop && in_dat && !prot && (|filled);
  wire [AW-PW-1:0] pg = ptr[AW-1:PW];

  assign busy = (timer != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timer <= '0;
    else if (commit) timer <= TW'(WR_CYCLES);
    else if (busy) timer <= timer - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (filled[i]) mem[{pg, PW'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_byte) pbuf[ptr[PW-1:0]] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= '0;
      hi      <= '0;
      prot    <= 1'b0;
      filled  <= '0;
      ack     <= 1'b0;
      rd_vld  <= 1'b0;
      rd_data <= 8'hFF;
    end else begin
      ack    <= 1'b0;
      rd_vld <= 1'b0;
      if (start_wr) begin
        ack <= !busy;
        st  <= busy ? S_IDLE : S_AH;
      end else if (start_rd) begin
        if (busy) st <= S_IDLE;
        else begin
          ack     <= 1'b1;
          rd_vld  <= 1'b1;
          rd_data <= mem[ptr];
          ptr     <= ptr + 1'b1;
          st      <= S_RD;
        end
      end else if (stop) begin
        st     <= S_IDLE;
        filled <= '0;
      end else if (byte_vld) begin
        case (st)
          S_AH: begin
            hi  <= byte_in[AW-9:0];
            ack <= 1'b1;
            st  <= S_AL;
          end
          S_AL: begin
            ptr    <= {hi, byte_in};
            prot   <= wp;
            filled <= '0;
            ack    <= 1'b1;
            st     <= S_DAT;
          end
          S_DAT: if (!prot) begin
            filled[ptr[PW-1:0]] <= 1'b1;
            ptr[PW-1:0]         <= ptr[PW-1:0] + 1'b1;
            ack                 <= 1'b1;
          end
          default: ;
        endcase
      end else if (rd_next && in_rd) begin
        rd_vld  <= 1'b1;
        rd_data <= mem[ptr];
        ptr     <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/page_wr_seq_chk.sv
module page_wr_seq_chk #(
  parameter int AW = 11,
  parameter int PW = 6,
  parameter int WR_CYCLES = 250000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_wr,
  input logic          start_rd,
  input logic          byte_vld,
  input logic          stop,
  input logic          rd_next,
  input logic          ack,
  input logic          busy,
  input logic          in_dat,
  input logic          in_rd,
  input logic          prot,
  input logic [AW-1:0] ptr,
  input logic          any_filled
);
  localparam int RW = $clog2(WR_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (busy) run <= run + 1'b1;
    else run <= '0;
  end

  assert_busy_noack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr || start_rd) && busy |=> !ack);

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < RW'(WR_CYCLES));

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == RW'(WR_CYCLES));

  assert_wp_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && in_dat && prot |=> !ack);

  assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && in_dat && !prot |=>
      ptr[AW-1:PW] == $past(ptr[AW-1:PW]) &&
      ptr[PW-1:0] == PW'($past(ptr[PW-1:0]) + 1'b1));

  assert_rd_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next && in_rd |=> ptr == AW'($past(ptr) + 1'b1));

  assert_empty_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !busy && !any_filled |=> !busy);
endmodule

bind page_wr_seq page_wr_seq_chk #(.AW(AW), .PW(PW), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
  .byte_vld(byte_vld), .stop(stop), .rd_next(rd_next), .ack(ack), .busy(busy),
  .in_dat(in_dat), .in_rd(in_rd), .prot(prot), .ptr(ptr), .any_filled(|filled)
);

// File: tb/page_wr_seq_tb.sv
`timescale 1ns/1ps
module page_wr_seq_tb;
  localparam int WRC = 40;
  localparam int E_SW = 0, E_SR = 1, E_BY = 2, E_SP = 3, E_NX = 4;

  logic clk = 1'b0, rst_n = 1'b0, wp = 1'b0;
  logic start_wr = 0, start_rd = 0, byte_vld = 0, stop = 0, rd_next = 0;
  logic [7:0] byte_in = 8'h00;
  logic ack, rd_vld, busy;
  logic [7:0] rd_data;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  page_wr_seq #(.AW(11), .PW(6), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp(wp), .start_wr(start_wr), .start_rd(start_rd),
    .byte_vld(byte_vld), .byte_in(byte_in), .stop(stop), .rd_next(rd_next),
    .ack(ack), .rd_vld(rd_vld), .rd_data(rd_data), .busy(busy));

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic ev(input int k, input logic [7:0] b, output logic a);
    @(negedge clk);
    byte_in = b;
    start_wr = (k == E_SW); start_rd = (k == E_SR); byte_vld = (k == E_BY);
    stop = (k == E_SP); rd_next = (k == E_NX);
    @(negedge clk);
    {start_wr, start_rd, byte_vld, stop, rd_next} = '0;
    a = ack;
  endtask

  task automatic set_addr(input logic [15:0] ad, input string tag);
    logic a;
    ev(E_SW, 0, a);        check({tag, " start ack"}, a, 1);
    ev(E_BY, ad[15:8], a); check({tag, " addr hi ack"}, a, 1);
    ev(E_BY, ad[7:0], a);  check({tag, " addr lo ack"}, a, 1);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic write1(input logic [15:0] ad, input logic [7:0] d);
    logic a; int n;
    set_addr(ad, "R3 write");
    ev(E_BY, d, a); check("R3 data ack", a, 1);
    ev(E_SP, 0, a);
    wait_idle(n);
  endtask

  task automatic read_seq(input logic [15:0] ad, input int cnt, input logic [7:0] exp[], input string tag);
    logic a;
    set_addr(ad, tag);
    ev(E_SR, 0, a);
    check({tag, " read ack"}, a, 1);
    check({tag, " rd_vld"}, rd_vld, 1);
    check({tag, " byte0"}, rd_data, exp[0]);
    for (int i = 1; i < cnt; i++) begin
      ev(E_NX, 0, a);
      check({tag, " next byte"}, rd_data, exp[i]);
    end
    ev(E_SP, 0, a);
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 ack", ack, 0);
    check("R1 rd_vld", rd_vld, 0);
    read_seq(16'h0010, 3, '{8'hFF, 8'hFF, 8'hFF}, "R1 blank");
  endtask

  task automatic t_byte_write;
    logic a; int n;
    set_addr(16'h0123, "R2");
    ev(E_BY, 8'hA5, a); check("R3 data ack", a, 1);
    ev(E_SP, 0, a);
    check("R3 busy after stop", busy, 1);
    wait_idle(n);
    check("R3 busy length", n, WRC);
    ev(E_SR, 0, a);
    check("R10 ptr after write ack", a, 1);
    check("R10 ptr after write", rd_data, 8'hFF);
    ev(E_SP, 0, a);
    read_seq(16'h0123, 1, '{8'hA5}, "R3 readback");
  endtask

  task automatic t_busy;
    logic a; int n;
    set_addr(16'h0130, "R6 setup");
    ev(E_BY, 8'h77, a);
    ev(E_SP, 0, a);
    ev(E_SW, 0, a); check("R6 start_wr during busy", a, 0);
    ev(E_BY, 8'h01, a); check("R6 byte during busy", a, 0);
    ev(E_BY, 8'h30, a); check("R6 byte during busy", a, 0);
    ev(E_SR, 0, a); check("R6 start_rd during busy", a, 0);
    ev(E_SP, 0, a);
    wait_idle(n);
    read_seq(16'h0130, 2, '{8'h77, 8'hFF}, "R6 unchanged");
  endtask

  task automatic t_page_wrap;
    logic a; int n; logic [7:0] exp[];
    set_addr(16'h0250, "R4");
    for (int k = 0; k < 66; k++) begin
      ev(E_BY, 8'(k), a); check("R4 data ack", a, 1);
    end
    ev(E_SP, 0, a);
    wait_idle(n);
    ev(E_SR, 0, a);
    check("R10 ptr wraps in page", rd_data, 8'd2);
    ev(E_SP, 0, a);
    exp = new[66];
    exp[0] = 8'hFF;
    for (int o = 0; o < 64; o++)
      exp[o+1] = (o == 16) ? 8'd64 : (o == 17) ? 8'd65 : 8'((o - 16) & 63);
    exp[65] = 8'hFF;
    read_seq(16'h023F, 66, exp, "R4 page");
  endtask

  task automatic t_partial;
    write1(16'h0260, 8'hEE);
    read_seq(16'h025F, 3, '{8'd15, 8'hEE, 8'd17}, "R5 partial");
  endtask

  task automatic t_wp;
    logic a; int n;
    wp = 1'b1;
    set_addr(16'h0300, "R7 protected");
    wp = 1'b0;
    ev(E_BY, 8'h12, a); check("R7 data nack", a, 0);
    ev(E_BY, 8'h34, a); check("R7 data nack", a, 0);
    ev(E_SP, 0, a);
    check("R7 no write cycle", busy, 0);
    read_seq(16'h0300, 2, '{8'hFF, 8'hFF}, "R7 unchanged");
    set_addr(16'h0310, "R7 late wp");
    wp = 1'b1;
    ev(E_BY, 8'h56, a); check("R7 late wp ack", a, 1);
    ev(E_SP, 0, a);
    wp = 1'b0;
    wait_idle(n);
    read_seq(16'h0310, 1, '{8'h56}, "R7 late wp written");
  endtask

  task automatic t_addr_only;
    logic a;
    set_addr(16'h8123, "R9");
    ev(E_SP, 0, a);
    check("R9 no busy", busy, 0);
    ev(E_SR, 0, a);
    check("R2 bit15 ignored", rd_data, 8'hA5);
    ev(E_NX, 0, a);
    check("R8 next", rd_data, 8'hFF);
    ev(E_SP, 0, a);
  endtask

  task automatic t_rd_wrap;
    write1(16'h07FF, 8'h5A);
    write1(16'h0000, 8'h3C);
    read_seq(16'h07FE, 3, '{8'hFF, 8'h5A, 8'h3C}, "R8 wrap");
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_byte_write;
    t_busy;
    t_page_wrap;
    t_partial;
    t_wp;
    t_addr_only;
    t_rd_wrap;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule